// File: doc/BRIEF.md
# Scheduled Stream Flow-Control Mover

This block is the per-node transfer engine of a mesh router whose traffic is planned ahead of time. On every cycle an external schedule names one of 32 virtual streams, or none. Each stream owns one instruction and one buffer word. The instruction holds a move opcode, a source and a destination. The engine reads the stream's source in the cycle after the stream is named and writes its destination in the cycle after that. It runs a valid/accept handshake on each of its five endpoints: four mesh links and the local processor link.

Each stream keeps a one-word buffer. A stream whose buffer is occupied refuses new input and replays the buffered word. A refused write parks the word in that buffer. Three further behaviours come from the same machinery. A destination can be another stream's buffer, which merges several streams into one. Two consecutive streams can share a port, which copies a word to several destinations. A conditional opcode repeats the outcome of the instruction before it, so that a multi-word message keeps its order and travels whole.

Top module: `stream_mover`

## Requirements
- R1: Every endpoint carries a 32-bit word plus a valid bit in each direction and returns one accept bit. Endpoint numbers are 0 = +X, 1 = -X, 2 = +Y, 3 = -Y and 4 = processor. At most one accept and at most one outgoing valid are raised in a cycle. The outgoing word is shown on all five data buses.
- R2: A stream named on the schedule in cycle t reads its source in cycle t+1 and drives its destination in cycle t+2. The word's own valid bit travels with it.
- R3: A stream that is not a blind move raises accept toward its source port only when its buffer is empty. When the buffer is full it raises no accept and takes the buffered word as its source.
- R4: A stream other than a blind move is never named on two consecutive cycles. A blind move may be.
- R5: When the captured source word is not valid, no outgoing valid is raised in the write cycle.
- R6: A write that the destination refuses leaves the word in the stream's buffer, and the next scheduling of that stream retries it.
- R7: Opcode 2 (blind move) raises accept on its source port, treats the source word as valid and raises the destination valid whatever the neighbour returns. It never touches its own buffer.
- R8: Opcode 1 (conditional move), placed right after an instruction that read a fresh word but had its write refused, raises no destination valid. Its word goes into its own buffer.
- R9: A conditional move placed right after an instruction whose read failed raises no accept and reads nothing, even when the source offers a valid word.
- R10: An endpoint code with bit 5 set and index k names stream k's buffer. As a destination, the write succeeds only when that buffer is empty; otherwise the word stays in the writer's buffer. As a source, it means the stream takes words from its own buffer only.
- R11: When the stream in its read cycle reads the port that the stream in its write cycle is driving, it takes that outgoing word. The write succeeds only when both the neighbour and the reading stream accept. If the reading stream's buffer is full, the outgoing valid is withheld.
- R12: After reset all buffers are empty and no accept or outgoing valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sched_vld | input | 1 | A stream is scheduled this cycle |
| sched_id | input | 5 | Scheduled stream number |
| cfg_we | input | 1 | Instruction table write strobe |
| cfg_idx | input | 5 | Stream whose instruction is written |
| cfg_op | input | 2 | Opcode: 0 flow-controlled, 1 conditional, 2 blind |
| cfg_src | input | 6 | Source endpoint code |
| cfg_dst | input | 6 | Destination endpoint code |
| rx_data | input | 160 | Incoming words, endpoint p at bits 32p+31:32p |
| rx_vld | input | 5 | Incoming valid per endpoint |
| rx_acc | output | 5 | Accept returned to each sending neighbour |
| tx_data | output | 160 | Outgoing word, endpoint p at bits 32p+31:32p |
| tx_vld | output | 5 | Outgoing valid per endpoint |
| tx_acc | input | 5 | Accept from each receiving neighbour |

## Verification
A vector table drives one flow-controlled stream through several cases. These are a clean pass, an empty source, a refused write, a full buffer that turns away fresh input, and a drain. Together they show whether accept follows buffer occupancy and whether a parked word wins over a newer one at the port. Directed sequences then try:
- back-to-back blind moves, which show that the handshake is ignored;
- a two-stream merge through a buffer destination, which shows the full-target fallback and in-order delivery;
- a fork across two consecutive streams, which separates a neighbour refusal from a full next stream;
- a flow/conditional pair under a clean pass, a refused write and a failed read, which shows that the pair succeeds or fails as one unit.

// File: rtl/stm_pkg.sv
package stm_pkg;
    typedef enum logic [1:0] {
        OP_FLOW  = 2'd0,
        OP_COND  = 2'd1,
        OP_BLIND = 2'd2,
        OP_RSVD  = 2'd3
    } mv_op_e;
endpackage

// File: rtl/stm_itab.sv
module stm_itab #(
    parameter int unsigned NSTR = 32,
    parameter int unsigned IW   = 14,
    localparam int unsigned SW  = $clog2(NSTR)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [IW-1:0] wr_word,
    input  logic [SW-1:0] rd_idx,
    output logic [IW-1:0] rd_word
);
    logic [IW-1:0] mem_q [NSTR];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_word;
    end

    assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/stm_bufbank.sv
module stm_bufbank #(
    parameter int unsigned NSTR = 32,
    parameter int unsigned DW   = 32,
    localparam int unsigned SW  = $clog2(NSTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            own_we,
    input  logic [SW-1:0]   own_idx,
    input  logic [DW-1:0]   own_data,
    input  logic            own_vld,
    input  logic            join_we,
    input  logic [SW-1:0]   join_idx,
    input  logic [DW-1:0]   join_data,
    input  logic [SW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic [NSTR-1:0] vld_q,
    output logic [NSTR-1:0] vld_d
);
    logic [DW-1:0] data_q [NSTR];

    // valid vector: next value computed here, registered below
    always_comb begin
        vld_d = vld_q;
        if (own_we)  vld_d[own_idx]  = own_vld;
        if (join_we) vld_d[join_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    // the data word is written unconditionally; only the valid bit is gated
    always_ff @(posedge clk) begin
        if (own_we)  data_q[own_idx]  <= own_data;
        if (join_we) data_q[join_idx] <= join_data;
    end

    assign rd_data = data_q[rd_idx];

    a_r6_refused_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (own_we && own_vld) |=> vld_q[$past(own_idx)]);

    a_r10_join_marks_full: assert property (@(posedge clk) disable iff (!rst_n)
        join_we |=> vld_q[$past(join_idx)]);
endmodule

// File: rtl/stream_mover.sv
module stream_mover #(
    parameter int unsigned NSTR  = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned NPORT = 5,
    localparam int unsigned SW   = $clog2(NSTR),
    localparam int unsigned EW   = SW + 1,
    localparam int unsigned PW   = $clog2(NPORT),
    localparam int unsigned IW   = 2 + 2 * EW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sched_vld,
    input  logic [SW-1:0]       sched_id,
    input  logic                cfg_we,
    input  logic [SW-1:0]       cfg_idx,
    input  logic [1:0]          cfg_op,
    input  logic [EW-1:0]       cfg_src,
    input  logic [EW-1:0]       cfg_dst,
    input  logic [NPORT*DW-1:0] rx_data,
    input  logic [NPORT-1:0]    rx_vld,
    output logic [NPORT-1:0]    rx_acc,
    output logic [NPORT*DW-1:0] tx_data,
    output logic [NPORT-1:0]    tx_vld,
    input  logic [NPORT-1:0]    tx_acc
);
    import stm_pkg::*;

    typedef struct packed {
        logic          r_act;     // read stage occupied
        logic [SW-1:0] r_id;
        mv_op_e        r_op;
        logic [EW-1:0] r_src;
        logic [EW-1:0] r_dst;
        logic          r_full;    // buffer status looked up one cycle early
        logic          w_act;     // write stage occupied
        logic [SW-1:0] w_id;
        mv_op_e        w_op;
        logic [EW-1:0] w_dst;
        logic [DW-1:0] w_data;
        logic          w_vld;
        logic          w_prev_rd; // read outcome of the instruction before
        logic          st_rd;     // status: last read fetched a fresh word
        logic          st_wr;     // status: last write completed
    } state_t;

    state_t s_q, s_d;

    logic [IW-1:0]   it_word;
    logic [DW-1:0]   buf_rd;
    logic [NSTR-1:0] buf_vld_q, buf_vld_d;
    logic            own_we, own_vld, join_we;
    logic [SW-1:0]   join_idx;

    stm_itab #(.NSTR(NSTR), .IW(IW)) u_itab (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_word ({cfg_op, cfg_src, cfg_dst}),
        .rd_idx  (sched_id),
        .rd_word (it_word)
    );

    stm_bufbank #(.NSTR(NSTR), .DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_we    (own_we),
        .own_idx   (s_q.w_id),
        .own_data  (s_q.w_data),
        .own_vld   (own_vld),
        .join_we   (join_we),
        .join_idx  (join_idx),
        .join_data (s_q.w_data),
        .rd_idx    (s_q.r_id),
        .rd_data   (buf_rd),
        .vld_q     (buf_vld_q),
        .vld_d     (buf_vld_d)
    );

    // endpoint decode for both stages
    logic          r_is_port, w_is_port, w_is_buf;
    logic [PW-1:0] r_sp, w_dp;
    logic [DW-1:0] rx_word;

    always_comb begin
        r_sp      = s_q.r_src[PW-1:0];
        w_dp      = s_q.w_dst[PW-1:0];
        r_is_port = !s_q.r_src[EW-1] && (s_q.r_src[SW-1:0] < SW'(NPORT));
        w_is_port = !s_q.w_dst[EW-1] && (s_q.w_dst[SW-1:0] < SW'(NPORT));
        w_is_buf  = s_q.w_dst[EW-1];
        join_idx  = s_q.w_dst[SW-1:0];
        rx_word   = r_is_port ? rx_data[int'(r_sp)*DW +: DW] : '0;
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_tx
            assign tx_data[p*DW +: DW] = s_q.w_data;
        end
    endgenerate

    logic w_force, cond_blk, fork_hit, nxt_acc, nxt_ok, w_succ, tgt_ok;
    logic acc_out, fresh, cap_vld;
    logic [DW-1:0] cap_data;

    always_comb begin
        s_d = s_q;

        // ---- write-stage qualifiers ----
        w_force  = (s_q.w_op == OP_COND) && s_q.w_prev_rd && !s_q.st_wr;
        cond_blk = (s_q.r_op == OP_COND) && !s_q.st_rd;
        fork_hit = s_q.w_act && (s_q.w_op != OP_BLIND) && s_q.w_vld && !w_force
                && w_is_port && s_q.r_act && r_is_port && (r_sp == w_dp);
        nxt_acc  = (s_q.r_op == OP_BLIND) || (!s_q.r_full && !cond_blk);
        nxt_ok   = fork_hit ? nxt_acc : 1'b1;

        // ---- write stage ----
        tx_vld  = '0;
        w_succ  = 1'b0;
        tgt_ok  = 1'b0;
        own_we  = 1'b0;
        own_vld = 1'b0;
        join_we = 1'b0;
        if (s_q.w_act) begin
            if (s_q.w_op == OP_BLIND) begin
                w_succ = 1'b1;
                if (w_is_port)     tx_vld[w_dp] = 1'b1;
                else if (w_is_buf) join_we      = 1'b1;
            end else begin
                own_we = 1'b1;
                if (s_q.w_vld && !w_force) begin
                    if (w_is_port) begin
                        tx_vld[w_dp] = nxt_ok;
                        w_succ       = tx_acc[w_dp] && nxt_ok;
                    end else if (w_is_buf) begin
                        tgt_ok  = !buf_vld_q[join_idx] && (join_idx != s_q.w_id)
                               && !(s_q.r_act && (s_q.r_id == join_idx));
                        join_we = tgt_ok;
                        w_succ  = tgt_ok;
                    end
                end
                own_vld = s_q.w_vld && !w_succ;
            end
        end

        // ---- read stage ----
        acc_out  = 1'b0;
        fresh    = 1'b0;
        cap_vld  = 1'b0;
        cap_data = '0;
        if (s_q.r_act) begin
            if (s_q.r_op == OP_BLIND) begin
                cap_vld  = 1'b1;
                fresh    = 1'b1;
                acc_out  = r_is_port && !fork_hit;
                cap_data = fork_hit ? s_q.w_data : (r_is_port ? rx_word : buf_rd);
            end else if (s_q.r_full) begin
                cap_vld  = 1'b1;
                cap_data = buf_rd;
            end else if (!cond_blk && r_is_port) begin
                if (fork_hit) begin
                    cap_vld  = w_succ;
                    cap_data = s_q.w_data;
                end else begin
                    acc_out  = 1'b1;
                    cap_vld  = rx_vld[r_sp];
                    cap_data = rx_word;
                end
                fresh = cap_vld;
            end
        end
        rx_acc = '0;
        if (acc_out) rx_acc[r_sp] = 1'b1;

        // ---- next state ----
        s_d.r_act     = sched_vld;
        s_d.r_id      = sched_id;
        s_d.r_op      = mv_op_e'(it_word[IW-1 -: 2]);
        s_d.r_src     = it_word[2*EW-1 -: EW];
        s_d.r_dst     = it_word[EW-1:0];
        s_d.r_full    = buf_vld_d[sched_id];
        s_d.w_act     = s_q.r_act;
        s_d.w_id      = s_q.r_id;
        s_d.w_op      = s_q.r_op;
        s_d.w_dst     = s_q.r_dst;
        s_d.w_data    = cap_data;
        s_d.w_vld     = cap_vld;
        s_d.w_prev_rd = s_q.st_rd;
        s_d.st_rd     = s_q.r_act && fresh;
        s_d.st_wr     = s_q.w_act && w_succ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r1_single_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_acc) && $onehot0(tx_vld));

    a_r3_accept_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.r_act && s_q.r_full && s_q.r_op != OP_BLIND) |-> (rx_acc == '0));

    a_r4_no_repeat_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_vld && s_q.r_act && s_q.r_op != OP_BLIND) |-> (sched_id != s_q.r_id));

    a_r5_invalid_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.w_act && s_q.w_op != OP_BLIND && !s_q.w_vld) |-> (tx_vld == '0));

    a_r8_forced_park: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.w_act && s_q.w_op == OP_COND && s_q.w_prev_rd && !s_q.st_wr) |-> (tx_vld == '0));
endmodule

// File: tb/stream_mover_tb.sv
module stream_mover_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sched_vld = 1'b0;
    logic [4:0]   sched_id = '0;
    logic         cfg_we = 1'b0;
    logic [4:0]   cfg_idx = '0;
    logic [1:0]   cfg_op = '0;
    logic [5:0]   cfg_src = '0, cfg_dst = '0;
    logic [159:0] rx_data = '0;
    logic [4:0]   rx_vld = '0;
    logic [4:0]   rx_acc;
    logic [159:0] tx_data;
    logic [4:0]   tx_vld;
    logic [4:0]   tx_acc = '0;

    stream_mover u_dut (
        .clk(clk), .rst_n(rst_n), .sched_vld(sched_vld), .sched_id(sched_id),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_op(cfg_op), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .rx_data(rx_data), .rx_vld(rx_vld), .rx_acc(rx_acc),
        .tx_data(tx_data), .tx_vld(tx_vld), .tx_acc(tx_acc)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [4:0]   o_rxacc, o_txvld;
    logic [159:0] o_txdata;

    typedef struct packed {
        logic        iv;
        logic [31:0] idat;
        logic        acc;
        logic        eacc;
        logic        eov;
        logic [31:0] eod;
    } fvec_t;

    // stream 1: flow move -X -> +Y
    localparam fvec_t FTAB [6] = '{
        '{1'b1, 32'hA000_0001, 1'b1, 1'b1, 1'b1, 32'hA000_0001},
        '{1'b0, 32'hDEAD_0000, 1'b1, 1'b1, 1'b0, 32'h0},
        '{1'b1, 32'hA000_0003, 1'b0, 1'b1, 1'b1, 32'hA000_0003},
        '{1'b1, 32'hA000_0004, 1'b0, 1'b0, 1'b1, 32'hA000_0003},
        '{1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 32'hA000_0003},
        '{1'b1, 32'hA000_0006, 1'b1, 1'b1, 1'b1, 32'hA000_0006}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] txw(input int p);
        return o_txdata[p*32 +: 32];
    endfunction

    // all tasks start and end at a falling edge
    task automatic tick(input logic sv, input logic [4:0] sid, input logic [4:0] rv,
                        input logic [31:0] rd, input logic [4:0] ta);
        sched_vld = sv; sched_id = sid; rx_vld = rv; rx_data = {5{rd}}; tx_acc = ta;
        #1;
        o_rxacc = rx_acc; o_txvld = tx_vld; o_txdata = tx_data;
        @(negedge clk);
    endtask

    task automatic idle();
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'd0);
    endtask

    task automatic cfg(input int idx, input logic [1:0] op, input logic [5:0] src,
                       input logic [5:0] dst);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_op = op; cfg_src = src; cfg_dst = dst;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: quiet after reset
        idle();
        chk("R12 rx_acc after reset", 32'(o_rxacc), 32'h0);
        chk("R12 tx_vld after reset", 32'(o_txvld), 32'h0);

        cfg(1, 2'd0, 6'd1,  6'd2);   // flow -X -> +Y
        cfg(2, 2'd2, 6'd0,  6'd4);   // blind +X -> proc
        cfg(3, 2'd0, 6'd4,  6'h25);  // flow proc -> buffer of stream 5
        cfg(5, 2'd0, 6'h20, 6'd2);   // flow own buffer -> +Y
        cfg(6, 2'd0, 6'd4,  6'd0);   // fork head: proc -> +X
        cfg(7, 2'd0, 6'd0,  6'd3);   // fork tail: +X -> -Y
        cfg(8, 2'd0, 6'd4,  6'd2);   // message head
        cfg(9, 2'd1, 6'd4,  6'd2);   // message body, conditional
        idle();

        // ---- vector table: single flow stream ----
        for (int i = 0; i < 6; i++) begin
            tick(1'b1, 5'd1, 5'd0, 32'h0, 5'd0);
            tick(1'b0, 5'd0, {3'b0, FTAB[i].iv, 1'b0}, FTAB[i].idat, 5'd0);
            chk($sformatf("R3 vec%0d accept", i), 32'(o_rxacc), {30'b0, FTAB[i].eacc, 1'b0});
            tick(1'b0, 5'd0, 5'd0, 32'h0, {2'b0, FTAB[i].acc, 2'b0});
            chk($sformatf("R2 R5 R6 vec%0d tx_vld", i), 32'(o_txvld), {29'b0, FTAB[i].eov, 2'b0});
            if (FTAB[i].eov) chk($sformatf("R1 R6 vec%0d data", i), txw(2), FTAB[i].eod);
            idle();
        end

        // ---- blind move, scheduled back to back ----
        tick(1'b1, 5'd2, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd2, 5'd0, 32'hB000_0001, 5'd0);
        chk("R7 blind accept without valid", 32'(o_rxacc), 32'h01);
        tick(1'b0, 5'd0, 5'd0, 32'hB000_0002, 5'd0);
        chk("R4 blind repeat accepts", 32'(o_rxacc), 32'h01);
        chk("R7 blind valid despite refusal", 32'(o_txvld), 32'h10);
        chk("R7 blind data 1", txw(4), 32'hB000_0001);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'd0);
        chk("R7 blind second valid", 32'(o_txvld), 32'h10);
        chk("R7 blind data 2", txw(4), 32'hB000_0002);
        idle();

        // ---- merge through a buffer destination ----
        tick(1'b1, 5'd3, 5'd0, 32'h0, 5'd0);
        tick(1'b0, 5'd0, 5'h10, 32'hC000_0001, 5'd0);
        chk("R10 join accept 1", 32'(o_rxacc), 32'h10);
        idle();
        chk("R10 join no port write", 32'(o_txvld), 32'h0);
        idle();
        tick(1'b1, 5'd3, 5'd0, 32'h0, 5'd0);
        tick(1'b0, 5'd0, 5'h10, 32'hC000_0002, 5'd0);
        chk("R10 join accept 2", 32'(o_rxacc), 32'h10);
        idle(); idle();
        tick(1'b1, 5'd3, 5'd0, 32'h0, 5'd0);
        tick(1'b0, 5'd0, 5'h10, 32'hC000_0003, 5'd0);
        chk("R10 R3 writer kept word", 32'(o_rxacc), 32'h0);
        idle(); idle();
        tick(1'b1, 5'd5, 5'd0, 32'h0, 5'd0);
        idle();
        chk("R10 merged stream takes no input", 32'(o_rxacc), 32'h0);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h04);
        chk("R10 merged out valid", 32'(o_txvld), 32'h04);
        chk("R10 merged first word", txw(2), 32'hC000_0001);
        idle();
        tick(1'b1, 5'd3, 5'd0, 32'h0, 5'd0);
        idle(); idle(); idle();
        tick(1'b1, 5'd5, 5'd0, 32'h0, 5'd0);
        idle();
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h04);
        chk("R10 merged second valid", 32'(o_txvld), 32'h04);
        chk("R10 merged second word", txw(2), 32'hC000_0002);
        idle();

        // ---- fork over two consecutive streams ----
        tick(1'b1, 5'd6, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd7, 5'h10, 32'hF000_0001, 5'd0);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h01);
        chk("R11 fork first leg", 32'(o_txvld), 32'h01);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h08);
        chk("R11 fork second leg", 32'(o_txvld), 32'h08);
        chk("R11 fork second data", txw(3), 32'hF000_0001);
        idle();

        tick(1'b1, 5'd6, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd7, 5'h10, 32'hF000_0002, 5'd0);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h00);
        chk("R11 fork shown to refusing neighbour", 32'(o_txvld), 32'h01);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h08);
        chk("R11 tail gets nothing on refusal", 32'(o_txvld), 32'h0);
        idle();

        tick(1'b1, 5'd6, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd7, 5'h10, 32'hF000_0003, 5'd0);
        chk("R6 fork head replays buffer", 32'(o_rxacc), 32'h0);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h01);
        chk("R6 fork retry data", txw(0), 32'hF000_0002);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h00);
        chk("R11 tail offered retried word", txw(3), 32'hF000_0002);
        idle();

        tick(1'b1, 5'd6, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd7, 5'h10, 32'hF000_0004, 5'd0);
        chk("R3 fork head accepts fresh", 32'(o_rxacc), 32'h10);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h01);
        chk("R11 valid withheld, tail full", 32'(o_txvld), 32'h0);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h08);
        chk("R11 tail drains parked word", txw(3), 32'hF000_0002);
        idle();

        tick(1'b1, 5'd6, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd7, 5'd0, 32'h0, 5'd0);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h01);
        chk("R11 held fork word first leg", txw(0), 32'hF000_0004);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h08);
        chk("R11 held fork word second leg", 32'(o_txvld), 32'h08);
        idle();

        // ---- head + conditional body ----
        tick(1'b1, 5'd8, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd9, 5'h10, 32'hD000_00A1, 5'd0);
        tick(1'b0, 5'd0, 5'h10, 32'hD000_00B1, 5'h04);
        chk("R9 body accepts after good read", 32'(o_rxacc), 32'h10);
        chk("R8 head data", txw(2), 32'hD000_00A1);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h04);
        chk("R8 body follows", txw(2), 32'hD000_00B1);
        idle();

        tick(1'b1, 5'd8, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd9, 5'h10, 32'hD000_00A2, 5'd0);
        tick(1'b0, 5'd0, 5'h10, 32'hD000_00B2, 5'h00);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h04);
        chk("R8 body parked after head refused", 32'(o_txvld), 32'h0);
        idle();

        tick(1'b1, 5'd8, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd9, 5'h10, 32'hD000_00A3, 5'd0);
        tick(1'b0, 5'd0, 5'h10, 32'hD000_00B3, 5'h04);
        chk("R8 retry head first", txw(2), 32'hD000_00A2);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h04);
        chk("R8 retry body in order", txw(2), 32'hD000_00B2);
        idle();

        tick(1'b1, 5'd8, 5'd0, 32'h0, 5'd0);
        tick(1'b1, 5'd9, 5'd0, 32'h0, 5'd0);
        tick(1'b0, 5'd0, 5'h10, 32'hD000_00B4, 5'h04);
        chk("R9 body refuses after failed head read", 32'(o_rxacc), 32'h0);
        chk("R5 head sends nothing", 32'(o_txvld), 32'h0);
        tick(1'b0, 5'd0, 5'd0, 32'h0, 5'h04);
        chk("R9 body sends nothing", 32'(o_txvld), 32'h0);
        idle();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule